// File: doc/BRIEF.md
# Multi-Plane Output Queue Port Controller

This block sits at one outlet of a switch built from several parallel, unbuffered switching planes. In every slot, each plane can deliver one request that carries a cell for this outlet. The block can store several of these cells in one slot, but it sends at most one cell per slot on its single output link. Every slot is one clock cycle. A request, its acknowledgment and its cell data all belong to the same cycle.

There are two operating modes. In loss mode the controller acknowledges every request. Cells that do not fit into the buffer are thrown away, and each dropped cell is counted. In backpressure mode the controller acknowledges only as many requests as the buffer can hold. Requests that are not acknowledged leave no trace, so the plane side can keep those cells and retry them. When only some requests can be served, lower-numbered planes are served first. The space available in a slot already includes the cell that is read out in that same slot.

Top module: `oq_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, `tx_vld` is 0, `drop_cnt` is 0, and `ack` is 0 while `req` is 0.
- R2: In a single cycle the block stores up to `NUM_PLANES` cells. Cells accepted in the same cycle leave on the output link in ascending plane index order, after all cells accepted in earlier cycles.
- R3: At most one cell leaves per cycle. `tx_vld`/`tx_data` show the oldest stored cell, which is removed at the next clock edge. A cell accepted in cycle t appears on the link no earlier than cycle t+1.
- R4: The free space seen by the requests of a cycle is `QDEPTH` minus the occupancy, plus one when the queue is not empty, because the read of that cycle is counted first.
- R5: In backpressure mode (`mode_bp`=1), `ack[i]` is 1 exactly for the requesting planes whose number of lower-indexed requesting planes is less than the free space. The acknowledgment is combinational, in the same cycle as the request.
- R6: In backpressure mode a request that is not acknowledged stores nothing, and `drop_cnt` does not change.
- R7: In loss mode (`mode_bp`=0) every request is acknowledged. The lowest-indexed requests that fit are stored, and the rest are discarded.
- R8: At each clock edge `drop_cnt` grows by the number of cells discarded in loss mode in that cycle, and it wraps at its width.
- R9: The default queue capacity is 16 cells. The occupancy never exceeds `QDEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_bp | input | 1 | 1 = backpressure mode, 0 = loss mode |
| req | input | NUM_PLANES | One request per plane for the current slot |
| req_data | input | NUM_PLANES*DATA_W | Cell of plane i in bits [i*DATA_W +: DATA_W] |
| ack | output | NUM_PLANES | Acknowledgment per plane, same cycle |
| tx_vld | output | 1 | Output link carries a cell this cycle |
| tx_data | output | DATA_W | Cell on the output link |
| drop_cnt | output | CNT_W | Number of cells discarded in loss mode, wrapping |

## Verification
The bench drives all four planes at once against a nearly full queue in both modes. The free space then covers only some of the requests. A design that forgets to count the read of the slot grants one plane too few. A design that grants in the wrong order, or leaves gaps, lets cells from the wrong plane through. Cells of one slot are checked against the ascending plane order on the link. A design that writes them to the wrong slots shows the swap. In loss mode the drop counter is compared every slot. A design that counts requests instead of cells lost, or that drops in backpressure mode, shows up there.

// File: rtl/oq_pkg.sv
// oq_pkg: shared definitions for the multi-plane output queue.
// Assumes nothing beyond a plain SystemVerilog compile order (first file).
package oq_pkg;

    // Operating mode of the controller, decoded from the single mode pin.
    typedef enum logic {
        OQ_MODE_LOSS  = 1'b0,
        OQ_MODE_BPRES = 1'b1
    } oq_mode_e;

    // Smaller of two unsigned values held in 32-bit integers.
    function automatic int unsigned oq_min(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/oq_grant.sv
// oq_grant: ranks the requesting planes in ascending index order and grants
// the first FREE of them. Outputs each plane's rank (number of lower-indexed
// requesters), which doubles as its write offset into the queue.
// Assumes: free never exceeds the queue depth; purely combinational.
module oq_grant #(
    parameter int NUM_PLANES = 4,
    parameter int RW         = 3,
    parameter int CW         = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PLANES-1:0]    req,
    input  logic [CW-1:0]            free,
    output logic [NUM_PLANES-1:0]    accept,
    output logic [NUM_PLANES*RW-1:0] rank_flat,
    output logic [RW-1:0]            n_req,
    output logic [RW-1:0]            n_acc
);
    import oq_pkg::*;

    // Prefix count of requests gives rank; grant while rank is below free.
    always_comb begin
        int unsigned run;
        run       = 0;
        accept    = '0;
        rank_flat = '0;
        for (int i = 0; i < NUM_PLANES; i++) begin
            rank_flat[i*RW +: RW] = RW'(run);
            accept[i]             = req[i] && (run < int'(free));
            run                   = run + int'(req[i]);
        end
        n_req = RW'(run);
        n_acc = RW'(oq_min(run, int'(free)));
    end

    // Grants are always a subset of requests.
    AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept & ~req) == '0);  // R5
    // Number of grants never exceeds free space.
    AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(accept) <= int'(free));  // R4

endmodule

// File: rtl/oq_store.sv
// oq_store: circular buffer with up to NUM_PLANES writes and one read per cycle.
// Each granted writer lands at write pointer + its rank, so cells of one cycle
// are laid down in ascending plane order. The head is shown combinationally.
// Assumes: QDEPTH is a power of two, QDEPTH >= NUM_PLANES, and the caller never
// writes more cells than the free space after the current read.
module oq_store #(
    parameter int NUM_PLANES = 4,
    parameter int QDEPTH     = 16,
    parameter int DATA_W     = 16,
    parameter int RW         = 3,
    parameter int CW         = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PLANES-1:0]        wr_en,
    input  logic [NUM_PLANES*RW-1:0]     wr_rank,
    input  logic [NUM_PLANES*DATA_W-1:0] wr_data,
    input  logic [RW-1:0]                wr_num,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            rd_data,
    output logic [CW-1:0]                count
);
    localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

    logic [DATA_W-1:0] mem [QDEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [CW-1:0]     count_q;

    // Store every granted cell at its ranked offset from the write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PLANES; i++) begin
            if (wr_en[i]) begin
                mem[PW'(wr_ptr + PW'(wr_rank[i*RW +: RW]))] <= wr_data[i*DATA_W +: DATA_W];
            end
        end
    end

    // Advance pointers and occupancy by the writes and the single read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            wr_ptr  <= PW'(wr_ptr + PW'(wr_num));
            rd_ptr  <= PW'(rd_ptr + PW'(rd_en));
            count_q <= CW'(count_q - CW'(rd_en) + CW'(wr_num));
        end
    end

    assign rd_data = mem[rd_ptr];
    assign count   = count_q;

    // Occupancy stays within capacity.
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= QDEPTH);  // R9
    // A read is only taken from a non-empty queue.
    AST_READ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> count_q != '0);  // R3

endmodule

// File: rtl/oq_drop_cnt.sv
// oq_drop_cnt: wrapping counter of cells discarded in loss mode.
// Assumes: inc is the number of cells lost in the current cycle.
module oq_drop_cnt #(
    parameter int RW    = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RW-1:0]    inc,
    output logic [CNT_W-1:0] cnt
);
    // Accumulate the losses of each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= CNT_W'(cnt + CNT_W'(inc));
    end

    // Each running cycle adds exactly that cycle's losses.
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cnt == CNT_W'($past(cnt) + CNT_W'($past(inc))));  // R8

endmodule

// File: rtl/oq_port_ctrl.sv
// oq_port_ctrl: output port controller of a multi-plane switch outlet.
// Accepts up to NUM_PLANES cells per cycle, sends one per cycle, and answers
// requests either for all (loss mode, overflow dropped) or only within free
// space (backpressure mode). Lower plane indices win when space is short.
// Assumes: one cycle per slot; QDEPTH power of two and >= NUM_PLANES.
module oq_port_ctrl #(
    parameter int NUM_PLANES = 4,
    parameter int QDEPTH     = 16,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_bp,
    input  logic [NUM_PLANES-1:0]        req,
    input  logic [NUM_PLANES*DATA_W-1:0] req_data,
    output logic [NUM_PLANES-1:0]        ack,
    output logic                         tx_vld,
    output logic [DATA_W-1:0]            tx_data,
    output logic [CNT_W-1:0]             drop_cnt
);
    import oq_pkg::*;

    localparam int RW = $clog2(NUM_PLANES + 1);
    localparam int CW = $clog2(QDEPTH + 1);

    oq_mode_e                  mode;
    logic [CW-1:0]             count;
    logic [CW-1:0]             free;
    logic                      pop;
    logic [NUM_PLANES-1:0]     accept;
    logic [NUM_PLANES*RW-1:0]  rank_flat;
    logic [RW-1:0]             n_req;
    logic [RW-1:0]             n_acc;
    logic [RW-1:0]             n_drop;

    // Decode mode, read decision and free space counted after the read.
    always_comb begin
        mode = oq_mode_e'(mode_bp);
        pop  = (count != '0);
        free = CW'(QDEPTH - int'(count) + int'(pop));
    end

    // Acknowledge per mode and count what loss mode throws away.
    always_comb begin
        if (mode == OQ_MODE_BPRES) begin
            ack    = accept;
            n_drop = '0;
        end else begin
            ack    = req;
            n_drop = RW'(n_req - n_acc);
        end
    end

    oq_grant #(
        .NUM_PLANES(NUM_PLANES), .RW(RW), .CW(CW)
    ) grant_i (
        .clk(clk), .rst_n(rst_n), .req(req), .free(free),
        .accept(accept), .rank_flat(rank_flat), .n_req(n_req), .n_acc(n_acc)
    );

    oq_store #(
        .NUM_PLANES(NUM_PLANES), .QDEPTH(QDEPTH), .DATA_W(DATA_W), .RW(RW), .CW(CW)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_rank(rank_flat),
        .wr_data(req_data), .wr_num(n_acc), .rd_en(pop),
        .rd_data(tx_data), .count(count)
    );

    oq_drop_cnt #(
        .RW(RW), .CNT_W(CNT_W)
    ) drop_i (
        .clk(clk), .rst_n(rst_n), .inc(n_drop), .cnt(drop_cnt)
    );

    assign tx_vld = pop;

    // Backpressure never acknowledges more than fits.
    AST_BP_ACK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bp |-> $countones(ack) <= int'(free));  // R5
    // Backpressure mode never loses cells.
    AST_BP_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bp |=> drop_cnt == $past(drop_cnt));  // R6
    // Loss mode answers every request.
    AST_QL_ACK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bp |-> (ack & req) == req);  // R7
    // Last cell leaves and nothing new arrives: link goes idle.
    AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(1) && req == '0) |=> !tx_vld);  // R3

endmodule

// File: tb/oq_port_ctrl_tb_top.sv
// Scoreboard bench: the driver predicts acks and pushes accepted cells into an
// expected queue; the monitor pops and compares what leaves on the link.
module oq_port_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int K          = 4;
    localparam int DEPTH      = 16;
    localparam int W          = 16;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_bp = 1'b0;
    logic [K-1:0]     req = '0;
    logic [K*W-1:0]   req_data = '0;
    logic [K-1:0]     ack;
    logic             tx_vld;
    logic [W-1:0]     tx_data;
    logic [CNT_W-1:0] drop_cnt;

    int          errors = 0;
    int          checks = 0;
    int          slot_no = 0;
    int          exp_drop = 0;
    bit          running = 1'b0;
    logic [W-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    oq_port_ctrl #(.NUM_PLANES(K), .QDEPTH(DEPTH), .DATA_W(W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_bp(mode_bp), .req(req), .req_data(req_data),
        .ack(ack), .tx_vld(tx_vld), .tx_data(tx_data), .drop_cnt(drop_cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: one cell per cycle, oldest first (R2, R3).
    always @(negedge clk) begin
        if (running) begin
            check(tx_vld == (exp_q.size() != 0), "R3 tx_vld", int'(tx_vld), int'(exp_q.size() != 0));
            if (exp_q.size() != 0) begin
                check(tx_data == exp_q[0], "R2 tx_data order", int'(tx_data), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
        end
    end

    // Driver: one slot with the given mode and request pattern.
    task automatic slot(input bit bp, input logic [K-1:0] r);
        int free;
        int run;
        logic [K-1:0] exp_ack;
        @(negedge clk);
        check(int'(drop_cnt) == exp_drop, "R8 drop_cnt", int'(drop_cnt), exp_drop);
        mode_bp = bp;
        req     = r;
        for (int i = 0; i < K; i++) req_data[i*W +: W] = W'((slot_no << 4) | i);
        #1;
        free = DEPTH - exp_q.size();   // monitor already removed this cycle's read (R4)
        run  = 0;
        exp_ack = '0;
        for (int i = 0; i < K; i++) begin
            if (r[i]) begin
                if (run < free) exp_q.push_back(W'((slot_no << 4) | i));
                else if (!bp) exp_drop++;
                exp_ack[i] = bp ? (run < free) : 1'b1;
                run++;
            end
        end
        if (bp) check(ack == exp_ack, "R5 R4 R6 ack backpressure", int'(ack), int'(exp_ack));
        else    check(ack == exp_ack, "R7 ack loss", int'(ack), int'(exp_ack));
        slot_no++;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_vld == 1'b0, "R1 tx_vld after reset", int'(tx_vld), 0);
        check(drop_cnt == '0, "R1 drop_cnt after reset", int'(drop_cnt), 0);
        check(ack == '0, "R1 ack idle", int'(ack), 0);
        running = 1'b1;
        // R5 R2: single and sparse requests in backpressure mode
        slot(1'b1, 4'b0001);
        slot(1'b1, 4'b1010);
        slot(1'b1, 4'b0000);
        // R9 R5 R6: saturate in backpressure mode, partial grants
        for (int n = 0; n < 8; n++) slot(1'b1, 4'b1111);
        slot(1'b1, 4'b0110);
        slot(1'b1, 4'b1100);
        // R7 R8: loss mode overflow
        for (int n = 0; n < 8; n++) slot(1'b0, 4'b1111);
        slot(1'b0, 4'b1011);
        // drain completely, then refill from empty in loss mode
        for (int n = 0; n < 24; n++) slot(1'b0, 4'b0000);
        check(exp_q.size() == 0, "R3 model drained", exp_q.size(), 0);
        slot(1'b0, 4'b0101);
        slot(1'b1, 4'b1111);
        for (int n = 0; n < 10; n++) slot(1'b1, 4'b0000);
        @(negedge clk);
        check(tx_vld == 1'b0, "R3 idle at end", int'(tx_vld), 0);
        check(int'(drop_cnt) == exp_drop, "R8 final drop_cnt", int'(drop_cnt), exp_drop);
        running = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule